// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads a two-level translation table held in an external word-addressed memory. A requester presents a virtual address, an access-type code and the current table base. The walker then issues one or two word reads on a request/response memory port. It decodes each returned descriptor and finishes with either a translation or a fault.

A translation carries the physical address and the attribute fields of the final descriptor. A fault carries the virtual address, the access type and the table level that failed. A first-level descriptor may map a whole 1 MB section, which ends the walk after one read. It may instead point to a second-level table whose entries map 4 KB pages.

The walker serves one request at a time. It accepts work only while idle and keeps its result on the outputs until the requester takes it. Caching of translations, permission enforcement and the table storage itself belong to other blocks.

Top module: `pgw_walker`

## Requirements
- R1: After reset `req_ready` is 1 and both `res_valid` and `mem_req_valid` are 0.
- R2: The table base is sampled when a request is accepted. The first read goes to word address {base[31:14], va[31:20], 2'b00}.
- R3: A first-level descriptor with low bits 2'b10 is a section. The result is PA = {desc[31:20], va[19:0]}, produced after exactly one memory read.
- R4: A first-level descriptor with low bits 2'b01 points to a second-level table. The second read goes to {desc[31:10], va[19:12], 2'b00}.
- R5: A second-level descriptor with nonzero low two bits is a 4 KB page. The result is PA = {desc[31:12], va[11:0]}, produced after exactly two reads.
- R6: A first-level descriptor with low bits 2'b00 or 2'b11 gives a fault with level 1 after one read.
- R7: A second-level descriptor with low bits 2'b00 gives a fault with level 2 after two reads.
- R8: A fault result has `res_fault`=1, `res_pa`=0 and all attribute outputs 0. Every result echoes the request's virtual address on `res_va` and its access code on `res_acc`.
- R9: While a walk is in progress `req_ready` is 0. A request presented then is neither taken nor answered.
- R10: Results are returned from the final descriptor's bits: `res_perm`=desc[3:2], `res_cache`=desc[5:4], `res_used`=desc[6], `res_domain`=desc[10:7]. All result outputs hold steady while `res_valid`=1 and `res_ready`=0.
- R11: While `mem_req_valid`=1 and `mem_req_ready`=0, the request stays asserted with an unchanged address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_va | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access-type code, echoed with the result |
| tbl_base | input | 32 | First-level table base, bits [31:14] used |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory takes the read request |
| mem_req_addr | output | 32 | Byte address of the descriptor word |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Descriptor word |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Requester takes the result |
| res_fault | output | 1 | Translation fault |
| res_level | output | 2 | Faulting level, 1 or 2 (0 on success) |
| res_pa | output | 32 | Physical address |
| res_perm | output | 2 | Permission field of final descriptor |
| res_cache | output | 2 | Cache attribute field |
| res_used | output | 1 | Accessed/modified flag |
| res_domain | output | 4 | Domain field |
| res_va | output | 32 | Virtual address of the request |
| res_acc | output | 2 | Access-type code of the request |

## Verification
A corrupted walk state shows at the ports within one or two cycles in one of three ways. The descriptor reads may land on the wrong word address, the number of reads per walk may differ from one or two, or the result may appear with the wrong fault level. Every read address and the read count are logged against a model of the table walk. A wrong captured base or virtual address therefore appears on the first read, before any result. Errors in the decoded fields show in the single result that follows, and holding `res_ready` low exposes any drift in the held result.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
    parameter int ADDR_W   = 32;
    parameter int OFF_W    = 12;
    parameter int L2_IDX_W = 8;
    localparam int L1_IDX_W   = ADDR_W - OFF_W - L2_IDX_W;
    localparam int SEC_W      = OFF_W + L2_IDX_W;
    localparam int L1_ALIGN   = L1_IDX_W + 2;
    localparam int L2_ALIGN   = L2_IDX_W + 2;
    localparam int PPN_W      = ADDR_W - OFF_W;
    localparam int SEC_BASE_W = ADDR_W - SEC_W;
    localparam int ACC_W      = 2;
    localparam int DOM_W      = 4;

    typedef enum logic [2:0] {
        ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_DONE
    } walk_state_e;

    typedef enum logic [1:0] {
        DT_NONE = 2'b00, DT_TABLE = 2'b01, DT_SECTION = 2'b10, DT_RSVD = 2'b11
    } l1_kind_e;

    typedef struct packed {
        logic [1:0]       perm;
        logic [1:0]       cache;
        logic             used;
        logic [DOM_W-1:0] domain;
    } page_attr_t;

    typedef struct packed {
        logic              fault;
        logic [1:0]        level;
        logic [ADDR_W-1:0] pa;
        page_attr_t        attr;
    } walk_result_t;

    function automatic page_attr_t attr_of(input logic [ADDR_W-1:0] d);
        page_attr_t a;
        a.perm   = d[3:2];
        a.cache  = d[5:4];
        a.used   = d[6];
        a.domain = d[10:7];
        return a;
    endfunction

    function automatic walk_result_t fault_at(input logic [1:0] lvl);
        walk_result_t r;
        r       = '0;
        r.fault = 1'b1;
        r.level = lvl;
        return r;
    endfunction
endpackage

// File: rtl/pgw_addr_gen.sv
module pgw_addr_gen
    import pgw_pkg::*;
(
    input  logic              second_lvl,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic [ADDR_W-1:0] l2_base,
    input  logic [ADDR_W-1:0] va,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] l1_addr;
    logic [ADDR_W-1:0] l2_addr;

    assign l1_addr = {tbl_base[ADDR_W-1:L1_ALIGN], va[ADDR_W-1:SEC_W], 2'b00};
    assign l2_addr = {l2_base[ADDR_W-1:L2_ALIGN], va[SEC_W-1:OFF_W], 2'b00};
    assign addr    = second_lvl ? l2_addr : l1_addr;
endmodule

// File: rtl/pgw_desc_decode.sv
module pgw_desc_decode
    import pgw_pkg::*;
(
    input  logic              second_lvl,
    input  logic [ADDR_W-1:0] desc,
    input  logic [ADDR_W-1:0] va,
    output logic              is_table,
    output logic [ADDR_W-1:0] next_base,
    output walk_result_t      res
);
    l1_kind_e kind;
    assign kind = l1_kind_e'(desc[1:0]);

    always_comb begin
        is_table  = 1'b0;
        next_base = {desc[ADDR_W-1:L2_ALIGN], {L2_ALIGN{1'b0}}};
        res       = '0;
        if (!second_lvl) begin
            case (kind)
                DT_TABLE: is_table = 1'b1;
                DT_SECTION: begin
                    res.pa   = {desc[ADDR_W-1:SEC_W], va[SEC_W-1:0]};
                    res.attr = attr_of(desc);
                end
                default: res = fault_at(2'd1);
            endcase
        end else if (desc[1:0] == 2'b00) begin
            res = fault_at(2'd2);
        end else begin
            res.pa   = {desc[ADDR_W-1:OFF_W], va[OFF_W-1:0]};
            res.attr = attr_of(desc);
        end
    end
endmodule

// File: rtl/pgw_walker.sv
module pgw_walker
    import pgw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_va,
    input  logic [ACC_W-1:0]  req_acc,
    input  logic [ADDR_W-1:0] tbl_base,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data,
    output logic              res_valid,
    input  logic              res_ready,
    output logic              res_fault,
    output logic [1:0]        res_level,
    output logic [ADDR_W-1:0] res_pa,
    output logic [1:0]        res_perm,
    output logic [1:0]        res_cache,
    output logic              res_used,
    output logic [DOM_W-1:0]  res_domain,
    output logic [ADDR_W-1:0] res_va,
    output logic [ACC_W-1:0]  res_acc
);
    walk_state_e       state;
    logic [ADDR_W-1:0] va_q;
    logic [ACC_W-1:0]  acc_q;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] l2base_q;
    walk_result_t      result_q;

    logic              dec_table;
    logic [ADDR_W-1:0] dec_next;
    walk_result_t      dec_res;

    pgw_addr_gen u_addr (
        .second_lvl (state == ST_L2_REQ),
        .tbl_base   (base_q),
        .l2_base    (l2base_q),
        .va         (va_q),
        .addr       (mem_req_addr)
    );

    pgw_desc_decode u_dec (
        .second_lvl (state == ST_L2_WAIT),
        .desc       (mem_rsp_data),
        .va         (va_q),
        .is_table   (dec_table),
        .next_base  (dec_next),
        .res        (dec_res)
    );

    assign req_ready     = (state == ST_IDLE);
    assign mem_req_valid = (state == ST_L1_REQ) || (state == ST_L2_REQ);
    assign res_valid     = (state == ST_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            va_q     <= '0;
            acc_q    <= '0;
            base_q   <= '0;
            l2base_q <= '0;
            result_q <= '0;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    va_q   <= req_va;
                    acc_q  <= req_acc;
                    base_q <= tbl_base;
                    state  <= ST_L1_REQ;
                end
                ST_L1_REQ: if (mem_req_ready) state <= ST_L1_WAIT;
                ST_L1_WAIT: if (mem_rsp_valid) begin
                    if (dec_table) begin
                        l2base_q <= dec_next;
                        state    <= ST_L2_REQ;
                    end else begin
                        result_q <= dec_res;
                        state    <= ST_DONE;
                    end
                end
                ST_L2_REQ: if (mem_req_ready) state <= ST_L2_WAIT;
                ST_L2_WAIT: if (mem_rsp_valid) begin
                    result_q <= dec_res;
                    state    <= ST_DONE;
                end
                ST_DONE: if (res_ready) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign res_fault  = result_q.fault;
    assign res_level  = result_q.level;
    assign res_pa     = result_q.pa;
    assign res_perm   = result_q.attr.perm;
    assign res_cache  = result_q.attr.cache;
    assign res_used   = result_q.attr.used;
    assign res_domain = result_q.attr.domain;
    assign res_va     = va_q;
    assign res_acc    = acc_q;

    // R9: an accepted request makes the walker busy on the next cycle
    a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R10: result held while not taken
    a_r10_result_hold: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_pa) && $stable(res_fault)
            && $stable(res_level) && $stable(res_va) && $stable(res_domain)));

    // R11: memory request held under backpressure
    a_r11_mem_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R8: a fault never carries a physical address
    a_r8_fault_no_pa: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_fault) |-> (res_pa == '0));

    // R6/R7: fault level is 1 or 2, success level is 0
    a_r6_fault_level: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_fault ? (res_level == 2'd1 || res_level == 2'd2) : (res_level == 2'd0)));

    // R1: no result and no memory request at the same time
    a_r1_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(res_valid && mem_req_valid));
endmodule

// File: tb/test_pgw_walker.sv
module test_pgw_walker;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic [1:0]  req_acc = '0;
    logic [31:0] tbl_base = '0;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        res_valid;
    logic        res_ready = 1'b0;
    logic        res_fault;
    logic [1:0]  res_level;
    logic [31:0] res_pa;
    logic [1:0]  res_perm;
    logic [1:0]  res_cache;
    logic        res_used;
    logic [3:0]  res_domain;
    logic [31:0] res_va;
    logic [1:0]  res_acc;

    always #(CLK_PERIOD/2) clk = ~clk;

    pgw_walker i_pgw_walker (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
        .req_acc(req_acc), .tbl_base(tbl_base),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data),
        .res_valid(res_valid), .res_ready(res_ready), .res_fault(res_fault),
        .res_level(res_level), .res_pa(res_pa), .res_perm(res_perm),
        .res_cache(res_cache), .res_used(res_used), .res_domain(res_domain),
        .res_va(res_va), .res_acc(res_acc)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int n_results = 0;
    int n_sent    = 0;
    bit stall_en  = 1'b0;
    bit hold_next = 1'b0;
    logic [7:0] cyc = '0;

    logic [31:0] mem [logic [31:0]];
    logic [31:0] rd_log [$];

    typedef struct {
        bit          fault;
        logic [1:0]  level;
        logic [31:0] pa;
        logic [1:0]  perm;
        logic [1:0]  cache;
        logic        used;
        logic [3:0]  domain;
        logic [31:0] va;
        logic [1:0]  acc;
        int          nreads;
        logic [31:0] a1;
        logic [31:0] a2;
    } exp_t;
    exp_t sb [$];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // Independent walk model built from the requirements
    function automatic exp_t model(input logic [31:0] va, input logic [1:0] acc, input logic [31:0] base);
        exp_t e;
        logic [31:0] d1, d2, fin;
        e = '{default: 0};
        e.va = va; e.acc = acc;
        e.a1 = {base[31:14], va[31:20], 2'b00};
        d1 = rd(e.a1);
        e.nreads = 1;
        fin = 32'h0;
        if (d1[1:0] == 2'b10) begin
            e.pa = {d1[31:20], va[19:0]}; fin = d1;
        end else if (d1[1:0] == 2'b01) begin
            e.a2 = {d1[31:10], va[19:12], 2'b00};
            d2 = rd(e.a2);
            e.nreads = 2;
            if (d2[1:0] == 2'b00) begin e.fault = 1; e.level = 2; end
            else begin e.pa = {d2[31:12], va[11:0]}; fin = d2; end
        end else begin
            e.fault = 1; e.level = 1;
        end
        if (!e.fault) begin
            e.perm = fin[3:2]; e.cache = fin[5:4]; e.used = fin[6]; e.domain = fin[10:7];
        end
        return e;
    endfunction

    assign mem_req_ready = !stall_en || cyc[0];

    // Behavioural table memory: one-cycle read latency
    always @(posedge clk) begin
        cyc <= cyc + 8'd1;
        if (rst) begin
            mem_rsp_valid <= 1'b0;
            mem_rsp_data  <= '0;
        end else begin
            mem_rsp_valid <= 1'b0;
            if (mem_req_valid && mem_req_ready) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= rd(mem_req_addr);
                rd_log.push_back(mem_req_addr);
            end
        end
    end

    // R11: port-level check of request stability under backpressure
    bit          prev_stalled = 1'b0;
    logic [31:0] prev_addr = '0;
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && prev_stalled) begin
                chk(mem_req_valid == 1'b1, "R11 req dropped", {31'b0, mem_req_valid}, 32'h1);
                chk(mem_req_addr == prev_addr, "R11 addr changed", mem_req_addr, prev_addr);
            end
            prev_stalled = !rst && mem_req_valid && !mem_req_ready;
            prev_addr    = mem_req_addr;
        end
    end

    // Monitor: pop and compare
    initial begin
        forever begin
            @(negedge clk);
            if (res_valid) begin
                exp_t e;
                n_results++;
                if (sb.size() == 0) begin
                    chk(1'b0, "R9 unexpected result", res_va, 32'h0);
                end else begin
                    e = sb.pop_front();
                    chk(res_fault == e.fault, "R6/R7 fault flag", {31'b0, res_fault}, {31'b0, e.fault});
                    chk(res_level == e.level, "R6/R7 level", {30'b0, res_level}, {30'b0, e.level});
                    chk(res_pa == e.pa, "R3/R5 physical address", res_pa, e.pa);
                    chk({res_perm, res_cache, res_used, res_domain} == {e.perm, e.cache, e.used, e.domain},
                        "R10 attributes", {23'b0, res_perm, res_cache, res_used, res_domain},
                        {23'b0, e.perm, e.cache, e.used, e.domain});
                    chk(res_va == e.va, "R8 echoed va", res_va, e.va);
                    chk(res_acc == e.acc, "R8 echoed access", {30'b0, res_acc}, {30'b0, e.acc});
                    chk(rd_log.size() == e.nreads, "R3/R5 read count", rd_log.size(), e.nreads);
                    if (rd_log.size() >= 1)
                        chk(rd_log[0] == e.a1, "R2 first-level address", rd_log[0], e.a1);
                    if (rd_log.size() >= 2 && e.nreads == 2)
                        chk(rd_log[1] == e.a2, "R4 second-level address", rd_log[1], e.a2);
                    if (hold_next) begin
                        for (int k = 0; k < 3; k++) begin
                            @(negedge clk);
                            chk(res_valid && res_pa == e.pa && res_va == e.va && res_fault == e.fault,
                                "R10 result held", res_pa, e.pa);
                        end
                        hold_next = 1'b0;
                    end
                end
                rd_log.delete();
                res_ready = 1'b1;
                @(negedge clk);
                res_ready = 1'b0;
            end
        end
    end

    task automatic send(input logic [31:0] va, input logic [1:0] acc, input logic [31:0] base);
        sb.push_back(model(va, acc, base));
        n_sent++;
        @(negedge clk);
        req_valid = 1'b1; req_va = va; req_acc = acc; tbl_base = base;
        forever begin
            if (req_ready) begin @(negedge clk); break; end
            @(negedge clk);
        end
        req_valid = 1'b0;
        tbl_base  = 32'hFFFF_FFFF;
    endtask

    task automatic drain();
        int guard = 0;
        while ((sb.size() != 0 || !req_ready) && guard < 200) begin
            @(negedge clk); guard++;
        end
    endtask

    bit finished = 1'b0;
    task automatic wrap_up();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 0, 1);
        wrap_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(req_ready == 1'b1, "R1 req_ready", {31'b0, req_ready}, 32'h1);
        chk(res_valid == 1'b0, "R1 res_valid", {31'b0, res_valid}, 32'h0);
        chk(mem_req_valid == 1'b0, "R1 mem_req_valid", {31'b0, mem_req_valid}, 32'h0);

        // R3 section at base 0x0010_0000, L1 index 0x004
        mem[32'h0010_0010] = 32'h1230_0000 | (4'hA << 7) | (1 << 6) | (2'b10 << 4) | (2'b01 << 2) | 2'b10;
        send(32'h0040_1234, 2'd1, 32'h0010_0000);
        drain();

        // R4/R5 page: va 0x00401234 -> pa 0x80010234
        mem[32'h0010_4010] = 32'h0020_0400 | 2'b01;
        mem[32'h0020_0404] = 32'h8001_0000 | (4'h5 << 7) | (2'b11 << 4) | (2'b10 << 2) | 2'b01;
        send(32'h0040_1234, 2'd2, 32'h0010_4000);
        drain();

        // R6 invalid and reserved first-level kinds
        mem[32'h0010_0020] = 32'hDEAD_BEEC;
        mem[32'h0010_0024] = 32'h1234_5673;
        send(32'h0080_0ABC, 2'd0, 32'h0010_0000);
        drain();
        send(32'h0090_0FFF, 2'd3, 32'h0010_0000);
        drain();

        // R7 invalid second level
        mem[32'h0010_0030] = 32'h0030_0001;
        mem[32'h0030_0000 + (8'h77 << 2)] = 32'hFFFF_FFFC;
        send(32'h00C7_7123, 2'd1, 32'h0010_0000);
        drain();

        // R11 memory backpressure with a page walk; type 2'b11 at L2 is a page
        stall_en = 1'b1;
        mem[32'h0020_0408] = 32'h4567_8000 | (1 << 6) | 2'b11;
        send(32'h0040_2FED, 2'd0, 32'h0010_4000);
        drain();
        stall_en = 1'b0;

        // R10 result hold while res_ready is low
        hold_next = 1'b1;
        send(32'h0040_1234, 2'd3, 32'h0010_0000);
        drain();

        // R9 request while busy is ignored
        send(32'h0040_1234, 2'd0, 32'h0010_4000);
        req_valid = 1'b1; req_va = 32'h0080_0000; req_acc = 2'd2; tbl_base = 32'h0010_0000;
        for (int k = 0; k < 2; k++) begin
            chk(req_ready == 1'b0, "R9 busy", {31'b0, req_ready}, 32'h0);
            @(negedge clk);
        end
        req_valid = 1'b0;
        drain();

        // Mixed patterns over one table
        for (int i = 0; i < 8; i++) begin
            logic [31:0] l1a, l2b;
            l1a = {18'h0200 >> 0, 12'(i + 16), 2'b00};
            l2b = 32'h0050_0000 + (i << 10);
            case (i % 4)
                0: mem[l1a] = (32'(i) << 24) | (32'(i) << 20) | (32'(i) << 7) | 2'b10;
                1: mem[l1a] = l2b | 2'b01;
                2: mem[l1a] = l2b | 2'b01;
                default: mem[l1a] = 32'h0;
            endcase
            mem[l2b + (32'(i) << 2)] = (i % 4 == 2) ? 32'h0 : ((32'h0A000 + i) << 12) | (32'(i) << 2) | 2'b01;
            stall_en = i[0];
            send({12'(i + 16), 8'(i), 12'(i * 37)}, 2'(i), 32'h0080_0000 + i);
            drain();
        end
        stall_en = 1'b0;

        repeat (5) @(negedge clk);
        chk(n_results == n_sent, "R9 result count", n_results, n_sent);
        chk(sb.size() == 0, "R9 pending results", sb.size(), 0);
        wrap_up();
    end
endmodule